// File: doc/BRIEF.md
# Configurable Stream Register Slice

This block sits on a point-to-point valid/ready stream and inserts one register stage into it. A word moves across either side of the slice in any cycle where that side's valid and ready are both high. The payload width is a parameter. A compile-time cut mode decides which handshake paths pass through flops:
- **Forward cut:** the upstream valid and data are registered, and ready is passed back combinationally.
- **Backward cut:** the upstream ready is driven from a flop, and valid and data pass through.
- **Full cut:** every path is registered and throughput stays at one word per cycle.
- **Half cut:** every path is registered using a single storage entry, at half throughput.

A synchronous flush input drops every word the slice holds at the next clock edge. Integrators choose the mode that breaks the critical timing path at a given stream boundary. They need not change the protocol on either side.

Top module: `stream_slice`

## Requirements
- R1: Words leave the slice in the order they entered, with none lost and none duplicated, in every mode. A word is accepted when `s_valid && s_ready` and delivered when `m_valid && m_ready`.
- R2: In forward cut, a word accepted into an empty slice appears on `m_valid`/`m_data` one cycle later. `s_ready` equals `!m_valid || m_ready` in the same cycle, with no clock edge in between.
- R3: In forward cut, with `s_valid` and `m_ready` held high, one word is accepted every cycle, with no bubbles.
- R4: In backward cut, `s_ready` does not change when `m_ready` changes within a cycle. With the slice empty, the input word is visible on `m_valid`/`m_data` in the same cycle.
- R5: In backward and full cut, a word accepted while the output stalls is held in a spare entry. `s_ready` is then low in the following cycle.
- R6: In full cut, a word accepted into an empty slice appears one cycle later. With `s_valid` and `m_ready` held high, one word is accepted every cycle.
- R7: In half cut, `s_ready` is low whenever `m_valid` is high. A word appears one cycle after acceptance. At most one word is accepted every two cycles.
- R8: In forward, full and half cut, once `m_valid` is high it stays high, with `m_data` unchanged, until the word is taken.
- R9: A flush makes `m_valid` low and `s_ready` high after the next clock edge. In backward cut, `m_valid` then follows `s_valid` directly.
- R10: After reset `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drops all held words at the next edge |
| s_valid | input | 1 | Upstream word present |
| s_ready | output | 1 | Slice can take a word |
| s_data | input | WIDTH | Upstream payload |
| m_valid | output | 1 | Word present towards downstream |
| m_ready | input | 1 | Downstream takes the word |
| m_data | output | WIDTH | Downstream payload |

## Verification
All four modes run side by side from a table of valid and ready patterns: steady flow, upstream gaps, downstream stalls, and both sides idle together. A scoreboard compares every delivered word with the next expected index, which separates a correct ordering from a lost, repeated or reordered word. Directed sequences then tell the modes apart:
- same-cycle or next-cycle visibility of a new word;
- whether `s_ready` reacts to `m_ready` without a clock edge;
- how many words enter in eight cycles of steady flow (eight against four);
- whether the spare entry closes `s_ready` after a stalled acceptance.

// File: rtl/sslice_pkg.sv
package sslice_pkg;
   typedef enum logic [1:0] {
      CUT_FWD  = 2'd0,
      CUT_BWD  = 2'd1,
      CUT_FULL = 2'd2,
      CUT_HALF = 2'd3
   } cut_mode_e;
endpackage

// File: rtl/sslice_fwd.sv
module sslice_fwd #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   logic             hold_v;
   logic [WIDTH-1:0] hold_d;

   assign in_ready  = !hold_v || out_ready;
   assign out_valid = hold_v;
   assign out_data  = hold_d;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         hold_v <= 1'b0;
      end else if (in_ready) begin
         hold_v <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_ready && in_valid) begin
         hold_d <= in_data;
      end
   end

   // R8
   fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
   // R9
   fwd_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);
endmodule

// File: rtl/sslice_skid.sv
module sslice_skid #(
   parameter int WIDTH   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   logic             spare_v;
   logic [WIDTH-1:0] spare_d;

   assign in_ready = !spare_v;

   if (REG_OUT) begin : g_regout
      logic             head_v;
      logic [WIDTH-1:0] head_d;
      logic             head_free;

      assign head_free = !head_v || out_ready;
      assign out_valid = head_v;
      assign out_data  = head_d;

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            head_v  <= 1'b0;
            spare_v <= 1'b0;
         end else if (head_free) begin
            if (spare_v) begin
               head_v  <= 1'b1;
               spare_v <= 1'b0;
            end else begin
               head_v <= in_valid;
            end
         end else if (in_valid && !spare_v) begin
            spare_v <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (head_free) begin
            head_d <= spare_v ? spare_d : in_data;
         end else if (in_valid && !spare_v) begin
            spare_d <= in_data;
         end
      end

      // R8
      full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
      // R9
      full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flush |=> (!out_valid && in_ready));
   end else begin : g_passout
      assign out_valid = spare_v || in_valid;
      assign out_data  = spare_v ? spare_d : in_data;

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            spare_v <= 1'b0;
         end else if (!spare_v) begin
            spare_v <= in_valid && !out_ready;
         end else if (out_ready) begin
            spare_v <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!spare_v && in_valid && !out_ready) begin
            spare_d <= in_data;
         end
      end

      // R9
      bwd_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flush |=> in_ready);
   end

   // R5
   skid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && out_valid && !out_ready && !flush) |=> !in_ready);
endmodule

// File: rtl/sslice_half.sv
module sslice_half #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   logic             slot_v;
   logic [WIDTH-1:0] slot_d;

   assign in_ready  = !slot_v;
   assign out_valid = slot_v;
   assign out_data  = slot_d;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         slot_v <= 1'b0;
      end else if (!slot_v) begin
         slot_v <= in_valid;
      end else if (out_ready) begin
         slot_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!slot_v && in_valid) begin
         slot_d <= in_data;
      end
   end

   // R7
   half_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
   // R7
   half_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !flush) |=> out_valid);
   // R8
   half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/stream_slice.sv
module stream_slice
   import sslice_pkg::*;
#(
   parameter int        WIDTH = 16,
   parameter cut_mode_e MODE  = CUT_FULL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [WIDTH-1:0] s_data,
   output logic             m_valid,
   input  logic             m_ready,
   output logic [WIDTH-1:0] m_data
);
   if (WIDTH < 1) begin : g_bad_width
      $error("stream_slice: WIDTH must be at least 1");
   end

   if (MODE == CUT_FWD) begin : g_fwd
      sslice_fwd #(.WIDTH(WIDTH)) u_cut (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
         .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data));
   end else if (MODE == CUT_HALF) begin : g_half
      sslice_half #(.WIDTH(WIDTH)) u_cut (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
         .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data));
   end else begin : g_skid
      sslice_skid #(.WIDTH(WIDTH), .REG_OUT(MODE == CUT_FULL)) u_cut (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
         .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data));
   end

   // R10
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (s_ready && (MODE == CUT_BWD || !m_valid)));
endmodule

// File: tb/stream_slice_test.sv
module stream_slice_test;
   import sslice_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int NV = 16;
   // {s_valid, m_ready, repeat[3:0]}
   localparam logic [5:0] VEC [NV] = '{
      6'b11_0011, 6'b10_0010, 6'b01_0011, 6'b11_0100,
      6'b10_0001, 6'b11_0001, 6'b01_0001, 6'b10_0011,
      6'b11_0010, 6'b00_0010, 6'b01_0010, 6'b11_0101,
      6'b10_0001, 6'b01_0001, 6'b11_0001, 6'b01_0100};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic iv = 1'b0;
   logic orr = 1'b0;
   logic [3:0] ir, ov;
   logic [W-1:0] id [4];
   logic [W-1:0] od [4];

   int in_cnt [4];
   int out_cnt [4];
   int checks = 0;
   int fails = 0;
   int inflow [4];
   logic [W-1:0] snap [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   // index: 0 forward, 1 backward, 2 full, 3 half
   stream_slice #(.WIDTH(W), .MODE(CUT_FULL)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .s_valid(iv), .s_ready(ir[2]), .s_data(id[2]),
      .m_valid(ov[2]), .m_ready(orr), .m_data(od[2]));
   stream_slice #(.WIDTH(W), .MODE(CUT_FWD)) uut_fwd (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .s_valid(iv), .s_ready(ir[0]), .s_data(id[0]),
      .m_valid(ov[0]), .m_ready(orr), .m_data(od[0]));
   stream_slice #(.WIDTH(W), .MODE(CUT_BWD)) uut_bwd (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .s_valid(iv), .s_ready(ir[1]), .s_data(id[1]),
      .m_valid(ov[1]), .m_ready(orr), .m_data(od[1]));
   stream_slice #(.WIDTH(W), .MODE(CUT_HALF)) uut_half (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .s_valid(iv), .s_ready(ir[3]), .s_data(id[3]),
      .m_valid(ov[3]), .m_ready(orr), .m_data(od[3]));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // apply inputs shortly after a falling edge, let them settle
   task automatic drive(input logic v, input logic r, input logic f);
      iv = v;
      orr = r;
      flush = f;
      for (int m = 0; m < 4; m++) id[m] = in_cnt[m][W-1:0];
      #1;
   endtask

   // record handshakes of this cycle, then cross the rising edge
   task automatic commit();
      for (int m = 0; m < 4; m++) begin
         if (iv && ir[m] && !flush) in_cnt[m]++;
         if (ov[m] && orr && !flush) begin
            check(od[m] == out_cnt[m][W-1:0], "R1 order", od[m], out_cnt[m] & 8'hff);
            out_cnt[m]++;
         end
      end
      @(negedge clk);
   endtask

   task automatic resync();
      for (int m = 0; m < 4; m++) out_cnt[m] = in_cnt[m];
   endtask

   task automatic drain();
      for (int k = 0; k < 4; k++) begin
         drive(1'b0, 1'b1, 1'b0);
         commit();
      end
   endtask

   initial begin
      for (int m = 0; m < 4; m++) begin
         in_cnt[m] = 0;
         out_cnt[m] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b0);
      // R10 reset state
      for (int m = 0; m < 4; m++) begin
         check(ov[m] == 1'b0, "R10 m_valid", ov[m], 0);
         check(ir[m] == 1'b1, "R10 s_ready", ir[m], 1);
      end

      // table-driven pattern walk (R1)
      for (int v = 0; v < NV; v++) begin
         for (int k = 0; k < int'(VEC[v][3:0]); k++) begin
            drive(VEC[v][5], VEC[v][4], 1'b0);
            commit();
         end
      end
      drain();
      for (int m = 0; m < 4; m++)
         check(in_cnt[m] == out_cnt[m], "R1 no loss", out_cnt[m], in_cnt[m]);

      // latency from empty
      drive(1'b1, 1'b1, 1'b0);
      check(ov[0] == 1'b0, "R2 fwd latency", ov[0], 0);
      check(ov[2] == 1'b0, "R6 full latency", ov[2], 0);
      check(ov[3] == 1'b0, "R7 half latency", ov[3], 0);
      check(ov[1] == 1'b1 && od[1] == id[1], "R4 bwd passthrough", od[1], id[1]);
      commit();
      drive(1'b0, 1'b1, 1'b0);
      check(ov[0] == 1'b1, "R2 fwd next cycle", ov[0], 1);
      check(ov[2] == 1'b1, "R6 full next cycle", ov[2], 1);
      check(ov[3] == 1'b1, "R7 half next cycle", ov[3], 1);
      commit();

      // ready paths within one cycle
      drive(1'b1, 1'b0, 1'b0);
      commit();
      drive(1'b0, 1'b0, 1'b0);
      check(ir[0] == 1'b0, "R2 fwd ready low", ir[0], 0);
      check(ir[1] == 1'b0, "R4 bwd ready low", ir[1], 0);
      drive(1'b0, 1'b1, 1'b0);
      check(ir[0] == 1'b1, "R2 fwd ready follows m_ready", ir[0], 1);
      check(ir[1] == 1'b0, "R4 bwd ready unmoved", ir[1], 0);
      commit();
      drain();

      // skid capture and hold under stall
      drive(1'b1, 1'b1, 1'b0);
      commit();
      drive(1'b1, 1'b0, 1'b0);
      commit();
      drive(1'b1, 1'b0, 1'b0);
      check(ir[2] == 1'b0, "R5 full spare closes ready", ir[2], 0);
      check(ir[1] == 1'b0, "R5 bwd spare closes ready", ir[1], 0);
      for (int m = 0; m < 4; m++) snap[m] = od[m];
      commit();
      drive(1'b1, 1'b0, 1'b0);
      for (int m = 0; m < 4; m++) begin
         if (m != 1) begin
            check(ov[m] == 1'b1, "R8 valid held", ov[m], 1);
            check(od[m] == snap[m], "R8 data stable", od[m], snap[m]);
         end
      end
      commit();
      drain();
      for (int m = 0; m < 4; m++)
         check(in_cnt[m] == out_cnt[m], "R5 no loss after stall", out_cnt[m], in_cnt[m]);

      // throughput over eight cycles of steady flow
      for (int m = 0; m < 4; m++) inflow[m] = in_cnt[m];
      for (int k = 0; k < 8; k++) begin
         drive(1'b1, 1'b1, 1'b0);
         commit();
      end
      check(in_cnt[0] - inflow[0] == 8, "R3 fwd throughput", in_cnt[0] - inflow[0], 8);
      check(in_cnt[2] - inflow[2] == 8, "R6 full throughput", in_cnt[2] - inflow[2], 8);
      check(in_cnt[3] - inflow[3] == 4, "R7 half throughput", in_cnt[3] - inflow[3], 4);
      drain();

      // flush drops held words
      drive(1'b1, 1'b0, 1'b0);
      commit();
      drive(1'b0, 1'b0, 1'b1);
      commit();
      drive(1'b0, 1'b0, 1'b0);
      for (int m = 0; m < 4; m++) begin
         check(ov[m] == 1'b0, "R9 flush valid", ov[m], 0);
         check(ir[m] == 1'b1, "R9 flush ready", ir[m], 1);
      end
      resync();
      drive(1'b1, 1'b0, 1'b0);
      check(ov[1] == 1'b1, "R9 bwd follows s_valid", ov[1], 1);
      commit();
      drain();
      for (int m = 0; m < 4; m++)
         check(in_cnt[m] == out_cnt[m], "R1 after flush", out_cnt[m], in_cnt[m]);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule